// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block sequences one conversion at a time for a successive-approximation analog-to-digital converter and is configured over a simple 32-bit memory-mapped bus. Software sets the settle delay, then writes one control word. That word powers the converter, picks one of eight analog inputs and enables the completion interrupt. The controller waits the programmed number of converter clocks so the analog front end can settle. It then finds the result one bit per clock. On each of those clocks it presents a trial code to the comparator and reads back a single "input is at or above the trial" bit.

When the last bit is decided, the result goes into the data word, right-justified with the upper bits zero. Busy drops and the interrupt status flag rises. The interrupt line follows status and enable together. Writing a control word with the power bit clear powers the converter down, abandons any conversion in flight and clears the pending interrupt. The converter clock is the bus clock, and the comparator is outside the block.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads zero, and `irq`, `adc_pwr`, `chan_sel` and `trial_code` are all zero.
- R2: Reads of any offset other than 0x00, 0x04, 0x08 and 0x0C return zero. Writes to the data word (0x00) and the status word (0x04) change nothing.
- R3: The control word sits at 0x08. Bits 2:0 are the channel, bit 3 is power, bit 5 is interrupt enable and bit 6 is interrupt status. Software cannot set bit 6. The channel and power fields appear on `chan_sel` and `adc_pwr`.
- R4: The settle-delay word at 0x0C holds 6 bits. Status bit 0 at 0x04 reads 1 for exactly D+1+RES clocks after the control write that starts a conversion, where D is the delay value (0 to 63) when that write lands.
- R5: `trial_code` is zero outside the bit search. During the search it shows the bits already decided, with the bit under test set, starting at the most significant bit and moving down one bit per clock. A bit is kept when `cmp_ge` is 1. The final result is min(input, 2^RES-1).
- R6: When the last bit is decided, the data word at 0x00 is loaded with the result, busy clears and interrupt status sets, all on the same clock edge.
- R7: `irq` is high exactly while interrupt status and interrupt enable are both 1.
- R8: While busy, a control write with the power bit set is ignored entirely. The channel, enable, status and the conversion in progress are all left unchanged.
- R9: A control write with the power bit clear drops `adc_pwr` and aborts any conversion in progress. Busy clears and the data word keeps its old value.
- R10: Every accepted control write clears interrupt status. A write with the power bit set and busy low starts a conversion on the channel written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| trial_code | output | RES | Trial code presented to the comparator |
| cmp_ge | input | 1 | Comparator: analog input is at or above `trial_code` |
| chan_sel | output | 3 | Analog input selected |
| adc_pwr | output | 1 | Converter power enable |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The bench runs conversions with inputs of zero, one, mid-scale, full scale and above full scale, so that drop-every-bit, keep-every-bit, alternating and clamped searches each show up in both the per-clock trial code and the final result. Settle delays of 0, 8, 20 and 63 separate off-by-one errors in the delay count from errors in the length of the bit search. Control writes arrive during idle, during the delay phase and during the bit search, with the power bit set and with it clear. These tell apart the cases that are ignored, that abort a conversion, and that only clear status. A conversion with interrupts disabled separates the status flag from the interrupt line.

// File: rtl/sar_pkg.sv
package sar_pkg;
    // register byte offsets
    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_STAT = 4;
    localparam int unsigned OFS_CTRL = 8;
    localparam int unsigned OFS_DLY  = 12;

    // control word bit positions
    localparam int unsigned CB_CHAN = 0;
    localparam int unsigned CB_PWR  = 3;
    localparam int unsigned CB_IE   = 5;
    localparam int unsigned CB_IST  = 6;

    localparam int unsigned CHAN_W = 3;
    localparam int unsigned DLY_W  = 6;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CONV = 1'b1
    } seq_st_e;
endpackage

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int unsigned RES    = 10,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [RES-1:0]    result,
    output logic              start,
    output logic              abort,
    output logic [CHAN_W-1:0] chan,
    output logic              pwr,
    output logic              ie,
    output logic              ist,
    output logic [DLY_W-1:0]  dly
);
    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              pwr;
        logic              ie;
        logic              ist;
        logic [DLY_W-1:0]  dly;
        logic [RES-1:0]    data;
    } regs_t;

    regs_t rg_d, rg_q;

    logic wr_ctrl, wr_dly, req_pwr, accept;
    logic unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:7], bus_wdata[CB_IST], bus_wdata[4]};

    always_comb begin
        wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_dly  = bus_sel && bus_wr && (bus_addr == ADDR_W'(OFS_DLY));
        req_pwr = bus_wdata[CB_PWR];
        // a powered start request is dropped while a conversion runs
        accept  = wr_ctrl && (!busy || !req_pwr);
        start   = accept && req_pwr;
        abort   = accept && !req_pwr && busy;

        rg_d = rg_q;
        if (accept) begin
            rg_d.chan = bus_wdata[CB_CHAN +: CHAN_W];
            rg_d.pwr  = req_pwr;
            rg_d.ie   = bus_wdata[CB_IE];
            rg_d.ist  = 1'b0;
        end
        if (done) begin
            rg_d.ist  = 1'b1;
            rg_d.data = result;
        end
        if (wr_dly) begin
            rg_d.dly = bus_wdata[DLY_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_DATA)) begin
            bus_rdata[RES-1:0] = rg_q.data;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[0] = busy;
        end else if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[CB_CHAN +: CHAN_W] = rg_q.chan;
            bus_rdata[CB_PWR]            = rg_q.pwr;
            bus_rdata[CB_IE]             = rg_q.ie;
            bus_rdata[CB_IST]            = rg_q.ist;
        end else if (bus_addr == ADDR_W'(OFS_DLY)) begin
            bus_rdata[DLY_W-1:0] = rg_q.dly;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign chan = rg_q.chan;
    assign pwr  = rg_q.pwr;
    assign ie   = rg_q.ie;
    assign ist  = rg_q.ist;
    assign dly  = rg_q.dly;
endmodule

// File: rtl/sar_dly.sv
module sar_dly #(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] load_val,
    output logic             waiting,
    output logic             expire
);
    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } dly_t;

    dly_t dl_d, dl_q;

    always_comb begin
        dl_d   = dl_q;
        expire = dl_q.run && (dl_q.cnt == '0) && !abort;
        if (start) begin
            dl_d.run = 1'b1;
            dl_d.cnt = load_val;
        end else if (dl_q.run) begin
            if (abort || dl_q.cnt == '0) begin
                dl_d.run = 1'b0;
            end else begin
                dl_d.cnt = dl_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_q <= '0;
        end else begin
            dl_q <= dl_d;
        end
    end

    assign waiting = dl_q.run;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int unsigned RES = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           launch,
    input  logic           abort,
    input  logic           cmp_ge,
    output logic [RES-1:0] trial_code,
    output logic           converting,
    output logic           done,
    output logic [RES-1:0] result
);
    localparam int unsigned IDX_W = (RES > 1) ? $clog2(RES) : 1;

    typedef struct packed {
        seq_st_e          st;
        logic [IDX_W-1:0] idx;
        logic [RES-1:0]   acc;
    } seq_t;

    seq_t sq_d, sq_q;
    logic [RES-1:0] trial, kept;

    always_comb begin
        trial  = sq_q.acc | (RES'(1) << sq_q.idx);
        kept   = cmp_ge ? trial : sq_q.acc;
        done   = (sq_q.st == SEQ_CONV) && (sq_q.idx == '0) && !abort;
        result = kept;

        sq_d = sq_q;
        case (sq_q.st)
            SEQ_IDLE: begin
                if (launch) begin
                    sq_d.st  = SEQ_CONV;
                    sq_d.idx = IDX_W'(RES - 1);
                    sq_d.acc = '0;
                end
            end
            SEQ_CONV: begin
                if (abort) begin
                    sq_d.st  = SEQ_IDLE;
                    sq_d.idx = '0;
                    sq_d.acc = '0;
                end else begin
                    sq_d.acc = kept;
                    if (sq_q.idx == '0) begin
                        sq_d.st = SEQ_IDLE;
                    end else begin
                        sq_d.idx = sq_q.idx - 1'b1;
                    end
                end
            end
            default: sq_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign converting = (sq_q.st == SEQ_CONV);
    assign trial_code = converting ? trial : '0;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned RES    = 10,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [RES-1:0]    trial_code,
    input  logic              cmp_ge,
    output logic [2:0]        chan_sel,
    output logic              adc_pwr,
    output logic              irq
);
    logic                 start, abort, waiting, expire, converting, done;
    logic                 busy, ie, ist;
    logic [DLY_W-1:0]     dly;
    logic [RES-1:0]       result;
    logic [CHAN_W-1:0]    chan;

    assign busy = waiting || converting;

    sar_regs #(.RES(RES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .start     (start),
        .abort     (abort),
        .chan      (chan),
        .pwr       (adc_pwr),
        .ie        (ie),
        .ist       (ist),
        .dly       (dly)
    );

    sar_dly #(.CNT_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .abort    (abort),
        .load_val (dly),
        .waiting  (waiting),
        .expire   (expire)
    );

    sar_seq #(.RES(RES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (expire),
        .abort      (abort),
        .cmp_ge     (cmp_ge),
        .trial_code (trial_code),
        .converting (converting),
        .done       (done),
        .result     (result)
    );

    assign chan_sel = chan;
    assign irq      = ist && ie;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int unsigned RES = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           ist,
    input logic           adc_pwr,
    input logic [2:0]     chan_sel,
    input logic [RES-1:0] trial_code
);
    AST_BUSY_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> adc_pwr); // R9
    AST_STATUS_FROM_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ist) |-> $past(busy)); // R6
    AST_DONE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && adc_pwr) |-> ist); // R6
    AST_CHAN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(chan_sel)); // R8
    AST_TRIAL_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (trial_code == '0)); // R5
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES(RES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .ist        (ist),
    .adc_pwr    (adc_pwr),
    .chan_sel   (chan_sel),
    .trial_code (trial_code)
);

// File: tb/sim_sar_adc_ctrl.sv
module sim_sar_adc_ctrl;
    localparam int RES    = 10;
    localparam int ADDR_W = 5;
    localparam int MAXV   = (1 << RES) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [RES-1:0]    trial_code;
    logic              cmp_ge;
    logic [2:0]        chan_sel;
    logic              adc_pwr;
    logic              irq;

    int vin [8];
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    assign cmp_ge = (vin[chan_sel] >= int'(trial_code));

    sar_adc_ctrl #(.RES(RES), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trial_code(trial_code), .cmp_ge(cmp_ge), .chan_sel(chan_sel),
        .adc_pwr(adc_pwr), .irq(irq)
    );

    // behavioural reference model
    int m_cnt, m_res, m_data, m_dly, m_chan;
    bit m_pwr, m_ie, m_ist;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_res = 0; m_data = 0; m_dly = 0; m_chan = 0;
            m_pwr = 0; m_ie = 0; m_ist = 0;
        end else begin
            if (bus_sel && bus_wr && bus_addr == 8 && !(m_cnt > 0 && bus_wdata[3])) begin
                m_chan = int'(bus_wdata[2:0]);
                m_pwr  = bus_wdata[3];
                m_ie   = bus_wdata[5];
                m_ist  = 0;
                if (bus_wdata[3]) begin
                    m_cnt = m_dly + 1 + RES;
                    m_res = (vin[m_chan] > MAXV) ? MAXV : vin[m_chan];
                end else begin
                    m_cnt = 0;
                end
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) begin
                    m_data = m_res;
                    m_ist  = 1;
                end
            end
            if (bus_sel && bus_wr && bus_addr == 12) m_dly = int'(bus_wdata[5:0]);
        end
    end

    function automatic longint exp_rd(input int a);
        case (a)
            0:  return m_data;
            4:  return (m_cnt > 0) ? 1 : 0;
            8:  return (m_ist << 6) | (m_ie << 5) | (m_pwr << 3) | m_chan;
            12: return m_dly;
            default: return 0;
        endcase
    endfunction

    function automatic string rd_tag(input int a);
        case (a)
            0:  return "R6";
            4:  return "R4";
            8:  return "R3";
            12: return "R4";
            default: return "R2";
        endcase
    endfunction

    function automatic longint exp_trial();
        if (m_cnt >= 1 && m_cnt <= RES)
            return ((m_res >> m_cnt) << m_cnt) | (1 << (m_cnt - 1));
        return 0;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(irq == (m_ist && m_ie), "R7 irq", irq, m_ist && m_ie);
            chk(adc_pwr == m_pwr, "R9 power", adc_pwr, m_pwr);
            chk(int'(chan_sel) == m_chan, "R3 channel", chan_sel, m_chan);
            chk(longint'(trial_code) == exp_trial(), "R5 trial", trial_code, exp_trial());
            if (bus_sel && !bus_wr)
                chk(longint'(bus_rdata) == exp_rd(int'(bus_addr)), rd_tag(int'(bus_addr)),
                    bus_rdata, exp_rd(int'(bus_addr)));
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input int a, input int d);
        bus_sel = 1; bus_wr = 1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 0; bus_addr = ADDR_W'(4); bus_wdata = 0;
    endtask

    task automatic rd(input int a, output int v);
        bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(a);
        @(negedge clk); v = int'(bus_rdata);
        @(posedge clk); #2;
        bus_addr = ADDR_W'(4);
    endtask

    task automatic wait_idle(output int busy_cycles);
        busy_cycles = 0;
        bus_sel = 1; bus_wr = 0; bus_addr = ADDR_W'(4);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (bus_rdata[0] == 1'b0) break;
            busy_cycles++;
            @(posedge clk); #2;
        end
        @(posedge clk); #2;
    endtask

    task automatic convert(input int d, input int ch, input bit en);
        int n, v;
        wr(12, d);
        wr(8, (en << 5) | 8 | ch);
        wait_idle(n);
        chk(n == d + 1 + RES, "R4 busy length", n, d + 1 + RES);
        rd(0, v);
        chk(v == ((vin[ch] > MAXV) ? MAXV : vin[ch]), "R5 result", v,
            (vin[ch] > MAXV) ? MAXV : vin[ch]);
        rd(8, v);
        chk(v[6] == 1'b1, "R6 status set", v[6], 1);
        chk(irq == en, "R7 irq level", irq, en);
    endtask

    initial begin
        int v;
        vin = '{682, 1023, 0, 2000, 1, 512, 300, 77};
        idle(3);
        rst_n = 1;
        idle(1);
        // R1 reset values
        for (int a = 0; a < 16; a += 4) begin
            rd(a, v);
            chk(v == 0, "R1 reset reg", v, 0);
        end
        chk(irq == 0 && adc_pwr == 0 && chan_sel == 0 && trial_code == 0,
            "R1 reset outputs", {irq, adc_pwr, chan_sel}, 0);

        convert(8, 0, 1);      // mid-scale alternating pattern
        wr(8, 0);              // power down clears request
        chk(irq == 0 && adc_pwr == 0, "R9 power down", {irq, adc_pwr}, 0);
        convert(0, 2, 1);      // zero input
        convert(0, 1, 1);      // full scale
        convert(63, 3, 1);     // above full scale, longest delay
        convert(8, 4, 1);      // one LSB
        convert(8, 5, 0);      // interrupts disabled

        // R10: accepted write without power clears status
        wr(8, 32);
        rd(8, v);
        chk(v == 32, "R10 status cleared", v, 32);

        // R8: powered start while busy is ignored
        wr(12, 20);
        wr(8, 32 | 8 | 7);
        idle(5);
        wr(8, 32 | 8 | 1);
        idle(14);
        wr(8, 32 | 8 | 6);
        begin
            int n;
            wait_idle(n);
        end
        rd(8, v);
        chk(v[2:0] == 3'd7, "R8 channel kept", v[2:0], 7);
        rd(0, v);
        chk(v == 77, "R8 result of first", v, 77);

        // R9: abort in delay phase and in bit search
        wr(12, 4);
        wr(8, 32 | 8 | 0);
        idle(3);
        wr(8, 32);
        rd(4, v);
        chk(v == 0, "R9 abort clears busy", v, 0);
        rd(0, v);
        chk(v == 77, "R9 data kept", v, 77);
        wr(8, 32 | 8 | 0);
        idle(9);
        wr(8, 0);
        rd(8, v);
        chk(v == 0, "R9 abort in search", v, 0);
        rd(0, v);
        chk(v == 77, "R9 data kept again", v, 77);

        // R2: read-only words and undefined offsets
        wr(0, 32'h3FF);
        wr(4, 1);
        rd(0, v);
        chk(v == 77, "R2 data write ignored", v, 77);
        rd(4, v);
        chk(v == 0, "R2 status write ignored", v, 0);
        foreach (vin[i]) begin
            int a;
            a = 16 + i * 2 + 1;
            rd(a, v);
            chk(v == 0, "R2 undefined offset", v, 0);
        end
        rd(2, v);
        chk(v == 0, "R2 unaligned offset", v, 0);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule